// File: doc/BRIEF.md
# Obstacle Runner Play-Field Core

This block holds the play-field and scoring state of a one-button dodge game. An 8-bit pseudorandom obstacle register advances one position per game tick. Its bits drive a row of obstacle lights, and bit 7 marks the player's position. A score counter climbs by one on each advance. A hit detector ends the round when an obstacle sits at the player's position on a tick and the player is not dodging. The round restarts at once from the seed pattern with a zero score.

The game tick comes from an internal divider. Its period is taken from the `period_i` input every cycle, so surrounding logic can shorten the period as the score grows and speed the game up. Display driving and button conditioning are left to neighbouring blocks. The dodge flag arrives already conditioned.

Top module: `runner_core`

## Requirements
- R1: While `rst_ni` is low, `field_o` is 8'h01, `score_o` is 0 and the tick divider count is 0. The first tick therefore comes `max(period_i,1)` cycles after reset is released.
- R2: On a tick edge without a hit, bits 6..0 of `field_o` move into bits 7..1.
- R3: The new bit 0 is `field_o[7] ^ field_o[5]`, using the default taps. `field_o` is never all zeros, and a zero next value is replaced by 8'h01.
- R4: `tick_o` is high for one cycle every `max(period_i,1)` clocks, with `period_i` = 0 treated as 1. If `period_i` drops below the count already reached, the tick comes in the very next cycle.
- R5: `field_o` and `score_o` change only at the end of a cycle in which `tick_o` is high.
- R6: On a tick edge without a hit, `score_o` rises by exactly one. It saturates at 255.
- R7: `game_over_o` is high exactly in cycles where `tick_o` is high, `field_o[7]` is 1 and `dodge_i` is low.
- R8: At the clock edge that ends a `game_over_o` cycle, `field_o` returns to 8'h01 and `score_o` returns to 0.
- R9: With `dodge_i` high on a tick, an obstacle at bit 7 causes no game over, and the field shifts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dodge_i | input | 1 | Player is dodging (already conditioned) |
| period_i | input | 8 | Tick period in clocks (0 acts as 1) |
| field_o | output | 8 | Obstacle pattern; bit 7 is the player position |
| score_o | output | 8 | Saturating score |
| game_over_o | output | 1 | Hit pulse, valid in a tick cycle |
| tick_o | output | 1 | Game tick strobe |

## Verification
The assertions assume that `dodge_i` and `period_i` are synchronous to `clk_i` and settle before each rising edge. They also assume the round starts from reset, so the field never holds a value the shift rule cannot reach. The bench changes both inputs only on the falling edge. It runs from a fresh reset before each scenario that depends on the field sequence, and it lowers `period_i` in the middle of a count to reach the early-tick corner case.

// File: rtl/runner_pkg.sv
package runner_pkg;
  localparam int unsigned FIELD_W_DEF = 8;
  localparam int unsigned SCORE_W_DEF = 8;
  localparam int unsigned PER_W_DEF   = 8;
  localparam int unsigned TAP_A_DEF   = 7;
  localparam int unsigned TAP_B_DEF   = 5;
endpackage

// File: rtl/runner_tick.sv
module runner_tick #(
  parameter int unsigned PER_W = runner_pkg::PER_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] last;

  // period 0 behaves as 1
  assign last   = (period_i == '0) ? '0 : period_i - PER_W'(1);
  assign tick_o = (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PER_W'(1);
  end
endmodule

// File: rtl/runner_field.sv
module runner_field #(
  parameter int unsigned FIELD_W = runner_pkg::FIELD_W_DEF,
  parameter int unsigned TAP_A   = runner_pkg::TAP_A_DEF,
  parameter int unsigned TAP_B   = runner_pkg::TAP_B_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               clear_i,
  output logic [FIELD_W-1:0] field_o
);
  localparam logic [FIELD_W-1:0] SEED = FIELD_W'(1);

  logic [FIELD_W-1:0] q, shifted, nxt;

  assign shifted[0] = q[TAP_A] ^ q[TAP_B];
  for (genvar i = 1; i < FIELD_W; i++) begin : g_shift
    assign shifted[i] = q[i-1];
  end

  always_comb begin
    if (clear_i)              nxt = SEED;
    else if (shifted == '0)   nxt = SEED;  // lock-up guard
    else                      nxt = shifted;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (step_i) q <= nxt;
  end

  assign field_o = q;
endmodule

// File: rtl/runner_score.sv
module runner_score #(
  parameter int unsigned SCORE_W = runner_pkg::SCORE_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               clear_i,
  output logic [SCORE_W-1:0] score_o
);
  localparam logic [SCORE_W-1:0] TOP = '1;

  logic [SCORE_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (step_i) begin
      if (clear_i)        q <= '0;
      else if (q != TOP)  q <= q + SCORE_W'(1);
    end
  end

  assign score_o = q;
endmodule

// File: rtl/runner_core.sv
module runner_core #(
  parameter int unsigned FIELD_W = runner_pkg::FIELD_W_DEF,
  parameter int unsigned SCORE_W = runner_pkg::SCORE_W_DEF,
  parameter int unsigned PER_W   = runner_pkg::PER_W_DEF,
  parameter int unsigned TAP_A   = runner_pkg::TAP_A_DEF,
  parameter int unsigned TAP_B   = runner_pkg::TAP_B_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dodge_i,
  input  logic [PER_W-1:0]   period_i,
  output logic [FIELD_W-1:0] field_o,
  output logic [SCORE_W-1:0] score_o,
  output logic               game_over_o,
  output logic               tick_o
);
  localparam int unsigned END_POS = FIELD_W - 1;

  logic tick, hit;

  runner_tick #(.PER_W(PER_W)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .tick_o   (tick)
  );

  // judged once per position: only in a tick cycle
  assign hit = tick & field_o[END_POS] & ~dodge_i;

  runner_field #(.FIELD_W(FIELD_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_field (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (tick),
    .clear_i (hit),
    .field_o (field_o)
  );

  runner_score #(.SCORE_W(SCORE_W)) u_score (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (tick),
    .clear_i (hit),
    .score_o (score_o)
  );

  assign game_over_o = hit;
  assign tick_o      = tick;
endmodule

// File: rtl/runner_core_chk.sv
module runner_core_chk #(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned SCORE_W = 8,
  parameter int unsigned PER_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               dodge_i,
  input logic [PER_W-1:0]   period_i,
  input logic [FIELD_W-1:0] field_o,
  input logic [SCORE_W-1:0] score_o,
  input logic               game_over_o,
  input logic               tick_o
);
  localparam logic [SCORE_W-1:0] TOP = '1;

  AST_FIELD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_o != '0); // R3
  AST_SHIFT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && !game_over_o |=> field_o[FIELD_W-1:1] == $past(field_o[FIELD_W-2:0])); // R2
  AST_HOLD_OFF_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(field_o) && $stable(score_o)); // R5
  AST_SCORE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && !game_over_o && score_o != TOP |=> score_o == $past(score_o) + SCORE_W'(1)); // R6
  AST_SCORE_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && !game_over_o && score_o == TOP |=> score_o == TOP); // R6
  AST_OVER_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    game_over_o |-> tick_o && field_o[FIELD_W-1] && !dodge_i); // R7
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    game_over_o |=> field_o == FIELD_W'(1) && score_o == '0); // R8
  AST_DODGE_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && dodge_i |-> !game_over_o); // R9
endmodule

bind runner_core runner_core_chk #(.FIELD_W(FIELD_W), .SCORE_W(SCORE_W), .PER_W(PER_W)) u_chk (.*);

// File: tb/runner_core_test.sv
`timescale 1ns/1ps
module runner_core_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dodge_i = 1'b0;
  logic [7:0] period_i = 8'd1;
  logic [7:0] field_o, score_o;
  logic       game_over_o, tick_o;

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0] m_field, m_score, m_cnt;
  logic       e_tick, e_over;

  always #5 clk_i = ~clk_i;

  runner_core uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .dodge_i(dodge_i), .period_i(period_i),
    .field_o(field_o), .score_o(score_o), .game_over_o(game_over_o), .tick_o(tick_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] nxt_field(logic [7:0] f);
    logic [7:0] n;
    n = {f[6:0], f[7] ^ f[5]};
    return (n == 8'h00) ? 8'h01 : n;
  endfunction

  // one clock: check outputs against the model, then advance the model
  task automatic cyc();
    logic [7:0] lst;
    #1;
    lst    = (period_i == 0) ? 8'd0 : period_i - 8'd1;
    e_tick = (m_cnt >= lst);
    e_over = e_tick && m_field[7] && !dodge_i;
    chk("R2 R3 R5 field", field_o, m_field);
    chk("R6 score", score_o, m_score);
    chk("R4 tick", tick_o, e_tick);
    chk("R7 R9 game_over", game_over_o, e_over);
    @(posedge clk_i);
    if (e_tick) begin
      if (e_over) begin m_field = 8'h01; m_score = 8'd0; end
      else begin
        m_field = nxt_field(m_field);
        if (m_score != 8'hFF) m_score = m_score + 8'd1;
      end
      m_cnt = 8'd0;
    end else m_cnt = m_cnt + 8'd1;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    #1;
    chk("R1 field", field_o, 8'h01);
    chk("R1 score", score_o, 8'd0);
    m_field = 8'h01; m_score = 8'd0; m_cnt = 8'd0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    period_i = 8'd3; dodge_i = 1'b1;
    do_reset();
    #1;
    chk("R1 no tick at count 0", tick_o, 0);
    @(negedge clk_i); #1;
    chk("R1 no tick at count 1", tick_o, 0);
    @(negedge clk_i); #1;
    chk("R1 first tick", tick_o, 1);
    do_reset();
  endtask

  task automatic t_period();
    int ticks = 0;
    period_i = 8'd4; dodge_i = 1'b1;
    do_reset();
    for (int i = 0; i < 40; i++) begin
      if (tick_o) ticks++;
      cyc();
    end
    chk("R4 tick count period 4", ticks, 10);
    chk("R5 score after 10 ticks", score_o, 10);
  endtask

  task automatic t_shrink();
    period_i = 8'd10; dodge_i = 1'b1;
    do_reset();
    for (int i = 0; i < 4; i++) cyc();
    period_i = 8'd2;
    #1;
    chk("R4 early tick after shrink", tick_o, 1);
    for (int i = 0; i < 8; i++) cyc();
  endtask

  task automatic t_zero();
    period_i = 8'd0; dodge_i = 1'b1;
    do_reset();
    for (int i = 0; i < 6; i++) begin
      #1;
      chk("R4 period 0 ticks each cycle", tick_o, 1);
      cyc();
    end
  endtask

  task automatic t_hit();
    bit seen = 0;
    period_i = 8'd1; dodge_i = 1'b0;
    do_reset();
    for (int i = 0; i < 20 && !seen; i++) begin
      #1;
      if (game_over_o) seen = 1;
      cyc();
    end
    chk("R7 hit reached", seen, 1);
    chk("R8 field restart", field_o, 8'h01);
    chk("R8 score restart", score_o, 0);
    for (int i = 0; i < 30; i++) cyc();
  endtask

  task automatic t_dodge();
    bit passed = 0;
    period_i = 8'd1; dodge_i = 1'b1;
    do_reset();
    for (int i = 0; i < 12; i++) begin
      #1;
      if (field_o[7]) begin
        chk("R9 no over while dodging", game_over_o, 0);
        passed = 1;
      end
      cyc();
    end
    chk("R9 obstacle at end seen", passed, 1);
  endtask

  task automatic t_mixed();
    period_i = 8'd2;
    do_reset();
    for (int i = 0; i < 120; i++) begin
      dodge_i = (i % 7) < 3;
      cyc();
    end
  endtask

  task automatic t_sat();
    period_i = 8'd1; dodge_i = 1'b1;
    do_reset();
    for (int i = 0; i < 300; i++) cyc();
    chk("R6 score saturated", score_o, 255);
    cyc();
    chk("R6 score holds at 255", score_o, 255);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_period();
    t_shrink();
    t_zero();
    t_hit();
    t_dodge();
    t_mixed();
    t_sat();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule